// File: doc/BRIEF.md
# System Exception Pend/Unpend and Status Register

This block is a single memory-mapped control word that software uses to pend or unpend three system exceptions: the non-maskable exception, the pendable service call and the periodic tick exception. Each of these three has a sticky pending flag inside the block. The flags feed the downstream prioritizer on dedicated output pins. A hardware source, such as the tick timer, can also set a flag directly.

A read of the word does not return stored data. It assembles a live status view from several sources. These are the three pending flags, the vector number the core is currently servicing, the highest-priority pending vector reported by the prioritizer, and two summary flags taken from the per-line active and pending vectors of the external interrupt lines. External line `i` carries vector number `16 + i`.

The read data path is combinational from the current inputs and flag state. A write takes effect on the flags at the next rising clock edge.

Top module: `exc_pend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three pending flags clear to 0, so `nmi_pend`, `svc_pend` and `tick_pend` read 0 after reset.
- R2: A write with bit 31 set pends the non-maskable exception from the next cycle on. Nothing in the word clears it, so it stays pending once set.
- R3: A write with bit 28 set pends the service-call exception. A write with bit 27 set and bit 28 clear unpends it. When both bits are set, the set wins.
- R4: A write with bit 26 set pends the tick exception. A write with bit 25 set and bit 26 clear unpends it. When both bits are set, the set wins.
- R5: A hardware pend request (`hw_nmi_req`, `hw_svc_req`, `hw_tick_req`) sets its flag on the next edge. It wins over a software unpend in the same cycle.
- R6: Write bits that are 0 have no effect. Writes to all other bits are ignored, which means bits 30, 29 and 24..0. Without a write and without a hardware request, every flag holds its value.
- R7: On read, bits 31, 28 and 26 show the live non-maskable, service-call and tick pending flags. Bits 27 and 25 read 0, as do all bits not named in R8 to R11.
- R8: Read bits [VEC_W-1:0] carry `act_vec` when `act_valid` is 1, and read 0 otherwise.
- R9: Read bits [12+VEC_W-1:12] carry `pv_vec` when `pv_valid` is 1, and read 0 otherwise.
- R10: Read bit 22 is 1 exactly when at least one bit of `ext_pend` is 1.
- R11: Read bit 11 is 1 exactly when some external line `i` has `ext_act[i]` set and is not the line being serviced. Line `i` is being serviced when `act_valid` is 1 and `act_vec` equals 16+i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| hw_nmi_req | input | 1 | Hardware pend request, non-maskable exception |
| hw_svc_req | input | 1 | Hardware pend request, service call |
| hw_tick_req | input | 1 | Hardware pend request, tick exception |
| act_valid | input | 1 | An exception is currently being serviced |
| act_vec | input | VEC_W | Vector number being serviced |
| pv_valid | input | 1 | A pending vector is reported |
| pv_vec | input | VEC_W | Highest-priority pending vector number |
| ext_act | input | NUM_EXT | Per-line active flags of the external lines |
| ext_pend | input | NUM_EXT | Per-line pending flags of the external lines |
| reg_rdata | output | 32 | Live status view of the control word |
| nmi_pend | output | 1 | Non-maskable exception pending, to prioritizer |
| svc_pend | output | 1 | Service-call exception pending, to prioritizer |
| tick_pend | output | 1 | Tick exception pending, to prioritizer |

## Verification
The properties assume that the vector inputs fit their field and that `VEC_W` is at most 10, so the two vector fields do not overlap bits 11 and 22. They also assume each hardware request is a one-cycle level sampled at the edge. The stimulus draws `act_vec` and `pv_vec` only from values that fit in `VEC_W` bits. The service vector is often aimed at a line that is itself active, so the "other active" flag is driven both ways. Software set and clear bits are mixed with hardware requests in the same cycle, which exercises the priority rules.

// File: rtl/exc_pend_pkg.sv
// Package: bit positions of the exception pend/status word and the
// per-exception encoding shared by the block and its submodules.
// Assumes a 32-bit word and three system exceptions.
package exc_pend_pkg;

    localparam int WORD_W        = 32;
    localparam int NUM_SYS       = 3;
    localparam int NMI_SET_POS   = 31;
    localparam int SVC_SET_POS   = 28;
    localparam int SVC_CLR_POS   = 27;
    localparam int TICK_SET_POS  = 26;
    localparam int TICK_CLR_POS  = 25;
    localparam int ANY_EXT_POS   = 22;
    localparam int OTHER_ACT_POS = 11;
    localparam int PEND_VEC_LSB  = 12;
    localparam int EXT_VEC_BASE  = 16;

    typedef enum int {
        SYS_NMI  = 0,
        SYS_SVC  = 1,
        SYS_TICK = 2
    } sys_exc_e;

    // Set-bit position of system exception k.
    function automatic int set_pos(input int k);
        case (k)
            SYS_NMI: return NMI_SET_POS;
            SYS_SVC: return SVC_SET_POS;
            default: return TICK_SET_POS;
        endcase
    endfunction

    // Clear-bit position of system exception k, or -1 when it has none.
    function automatic int clr_pos(input int k);
        case (k)
            SYS_NMI: return -1;
            SYS_SVC: return SVC_CLR_POS;
            default: return TICK_CLR_POS;
        endcase
    endfunction

endpackage

// File: rtl/exc_pend_bit.sv
// Module: exc_pend_bit
// One sticky pending flag of a system exception. A hardware request or a
// software set pends it. A software clear unpends it, unless a set or a
// hardware request arrives in the same cycle.
// Assumes: set_bit/clr_bit are only meaningful when wr is 1; a clear is
// already qualified by the caller as "set bit not written".
module exc_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic set_bit,
    input  logic clr_bit,
    input  logic hw_req,
    output logic pend
);

    logic do_set;
    logic do_clr;
    logic pend_q;

    // Decode the software set and clear for this cycle.
    always_comb begin
        do_set = (wr & set_bit) | hw_req;
        do_clr = wr & clr_bit;
    end

    // Sticky flag: set or hardware request wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (do_set) begin
            pend_q <= 1'b1;
        end else if (do_clr) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    AST_SW_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && set_bit) |=> pend); // R3
    AST_HW_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |=> pend); // R5
    AST_SW_CLR_UNPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && clr_bit && !set_bit && !hw_req) |=> !pend); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && (set_bit || clr_bit)) && !hw_req) |=> $stable(pend)); // R6

endmodule

// File: rtl/exc_ext_summary.sv
// Module: exc_ext_summary
// Reduces the per-line active/pending vectors of the external lines to two
// summary flags: any line pending, and any active line other than the one
// being serviced. Line i carries vector EXT_VEC_BASE + i.
// Assumes: EXT_VEC_BASE + NUM_EXT - 1 fits in VEC_W bits.
module exc_ext_summary
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXT = 64,
    parameter int VEC_W   = 9
) (
    input  logic [NUM_EXT-1:0] ext_act,
    input  logic [NUM_EXT-1:0] ext_pend,
    input  logic               act_valid,
    input  logic [VEC_W-1:0]   act_vec,
    output logic               any_pend,
    output logic               other_act
);

    logic [NUM_EXT-1:0] other_hit;

    // Per line: active and not the line currently being serviced.
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_line
        localparam logic [VEC_W-1:0] LINE_VEC = VEC_W'(EXT_VEC_BASE + i);
        assign other_hit[i] = ext_act[i] & ~(act_valid & (act_vec == LINE_VEC));
    end

    // Summary reductions.
    always_comb begin
        any_pend  = |ext_pend;
        other_act = |other_hit;
    end

endmodule

// File: rtl/exc_read_fmt.sv
// Module: exc_read_fmt
// Assembles the live read view of the control word from the pending flags,
// the serviced vector, the reported pending vector and the summary flags.
// Assumes: VEC_W <= 10 so neither vector field reaches bit 11 or bit 22.
module exc_read_fmt
    import exc_pend_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic [NUM_SYS-1:0] pend,
    input  logic               act_valid,
    input  logic [VEC_W-1:0]   act_vec,
    input  logic               pv_valid,
    input  logic [VEC_W-1:0]   pv_vec,
    input  logic               any_pend,
    input  logic               other_act,
    output logic [WORD_W-1:0]  rdata
);

    // Place each status source at its field; unused bits read 0.
    always_comb begin
        rdata                            = '0;
        rdata[NMI_SET_POS]               = pend[SYS_NMI];
        rdata[SVC_SET_POS]               = pend[SYS_SVC];
        rdata[TICK_SET_POS]              = pend[SYS_TICK];
        rdata[ANY_EXT_POS]               = any_pend;
        rdata[OTHER_ACT_POS]             = other_act;
        if (act_valid) begin
            rdata[VEC_W-1:0]             = act_vec;
        end
        if (pv_valid) begin
            rdata[PEND_VEC_LSB +: VEC_W] = pv_vec;
        end
    end

endmodule

// File: rtl/exc_pend_ctrl.sv
// Module: exc_pend_ctrl (top)
// Exception pend/unpend control word with live status read. Holds three
// sticky pending flags (non-maskable, service call, tick) that drive the
// prioritizer, and builds the read view from live inputs.
// Assumes: single-cycle write strobe; read data is combinational.
module exc_pend_ctrl
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXT = 64,
    parameter int VEC_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               hw_nmi_req,
    input  logic               hw_svc_req,
    input  logic               hw_tick_req,
    input  logic               act_valid,
    input  logic [VEC_W-1:0]   act_vec,
    input  logic               pv_valid,
    input  logic [VEC_W-1:0]   pv_vec,
    input  logic [NUM_EXT-1:0] ext_act,
    input  logic [NUM_EXT-1:0] ext_pend,
    output logic [31:0]        reg_rdata,
    output logic               nmi_pend,
    output logic               svc_pend,
    output logic               tick_pend
);

    logic [NUM_SYS-1:0] hw_req;
    logic [NUM_SYS-1:0] set_w;
    logic [NUM_SYS-1:0] clr_w;
    logic [NUM_SYS-1:0] pend_q;
    logic               any_pend;
    logic               other_act;
    logic               wdata_unused;

    // Gather the hardware requests by exception index.
    always_comb begin
        hw_req[SYS_NMI]  = hw_nmi_req;
        hw_req[SYS_SVC]  = hw_svc_req;
        hw_req[SYS_TICK] = hw_tick_req;
    end

    // Read-only and reserved write bits are deliberately dropped.
    assign wdata_unused = ^reg_wdata;

    // One pending flag per system exception; clear only where one exists.
    for (genvar k = 0; k < NUM_SYS; k++) begin : g_sys
        localparam int SP = set_pos(k);
        localparam int CP = clr_pos(k);
        assign set_w[k] = reg_wdata[SP];
        if (CP >= 0) begin : g_clr
            assign clr_w[k] = reg_wdata[CP] & ~reg_wdata[SP];
        end else begin : g_noclr
            assign clr_w[k] = 1'b0;
        end
        exc_pend_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (reg_wr),
            .set_bit (set_w[k]),
            .clr_bit (clr_w[k]),
            .hw_req  (hw_req[k]),
            .pend    (pend_q[k])
        );
    end

    exc_ext_summary #(
        .NUM_EXT (NUM_EXT),
        .VEC_W   (VEC_W)
    ) u_summary (
        .ext_act   (ext_act),
        .ext_pend  (ext_pend),
        .act_valid (act_valid),
        .act_vec   (act_vec),
        .any_pend  (any_pend),
        .other_act (other_act)
    );

    exc_read_fmt #(
        .VEC_W (VEC_W)
    ) u_fmt (
        .pend      (pend_q),
        .act_valid (act_valid),
        .act_vec   (act_vec),
        .pv_valid  (pv_valid),
        .pv_vec    (pv_vec),
        .any_pend  (any_pend),
        .other_act (other_act),
        .rdata     (reg_rdata)
    );

    // Drive the prioritizer-facing flags.
    always_comb begin
        nmi_pend  = pend_q[SYS_NMI];
        svc_pend  = pend_q[SYS_SVC];
        tick_pend = pend_q[SYS_TICK];
    end

    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |=> nmi_pend); // R2
    AST_ANY_EXT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ext_pend) != 0) |-> reg_rdata[ANY_EXT_POS]); // R10
    AST_NO_OTHER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_act == '0) |-> !reg_rdata[OTHER_ACT_POS]); // R11
    AST_TWO_ACTIVE_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ext_act) > 1) |-> reg_rdata[OTHER_ACT_POS]); // R11
    AST_ACT_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |-> (reg_rdata[VEC_W-1:0] == '0)); // R8
    AST_PV_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pv_valid |-> (reg_rdata[PEND_VEC_LSB +: VEC_W] == '0)); // R9

endmodule

// File: tb/tb_exc_pend_ctrl.sv
// Bench: behavioural reference model of the pend flags and read view,
// compared field by field on every clock.
module tb_exc_pend_ctrl;

    localparam int NUM_EXT = 64;
    localparam int VEC_W   = 9;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr;
    logic [31:0]        reg_wdata;
    logic               hw_nmi_req, hw_svc_req, hw_tick_req;
    logic               act_valid, pv_valid;
    logic [VEC_W-1:0]   act_vec, pv_vec;
    logic [NUM_EXT-1:0] ext_act, ext_pend;
    logic [31:0]        reg_rdata;
    logic               nmi_pend, svc_pend, tick_pend;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  m_nmi, m_svc, m_tick;

    always #5 clk = ~clk;

    exc_pend_ctrl #(.NUM_EXT(NUM_EXT), .VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .hw_nmi_req(hw_nmi_req), .hw_svc_req(hw_svc_req), .hw_tick_req(hw_tick_req),
        .act_valid(act_valid), .act_vec(act_vec), .pv_valid(pv_valid), .pv_vec(pv_vec),
        .ext_act(ext_act), .ext_pend(ext_pend), .reg_rdata(reg_rdata),
        .nmi_pend(nmi_pend), .svc_pend(svc_pend), .tick_pend(tick_pend)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Expected read word from the model flags and the current inputs.
    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        bit other = 1'b0;
        w[31] = m_nmi;
        w[28] = m_svc;
        w[26] = m_tick;
        w[22] = (ext_pend != '0);
        for (int i = 0; i < NUM_EXT; i++) begin
            if (ext_act[i] && !(act_valid && (int'(act_vec) == 16 + i))) other = 1'b1;
        end
        w[11] = other;
        if (act_valid) w[VEC_W-1:0] = act_vec;
        if (pv_valid)  w[12 +: VEC_W] = pv_vec;
        return w;
    endfunction

    // Compare every field now, then advance the model across one edge.
    task automatic step();
        logic [31:0] e;
        #2;
        e = exp_word();
        chk("R2 nmi flag",      {31'd0, reg_rdata[31]}, {31'd0, e[31]});
        chk("R2 nmi pin",       {31'd0, nmi_pend},      {31'd0, m_nmi});
        chk("R3 svc flag",      {31'd0, reg_rdata[28]}, {31'd0, e[28]});
        chk("R3 svc pin",       {31'd0, svc_pend},      {31'd0, m_svc});
        chk("R4 tick flag",     {31'd0, reg_rdata[26]}, {31'd0, e[26]});
        chk("R4 tick pin",      {31'd0, tick_pend},     {31'd0, m_tick});
        chk("R8 active field",  32'(reg_rdata[VEC_W-1:0]),  32'(e[VEC_W-1:0]));
        chk("R9 pending field", 32'(reg_rdata[12 +: VEC_W]), 32'(e[12 +: VEC_W]));
        chk("R10 any pending",  {31'd0, reg_rdata[22]}, {31'd0, e[22]});
        chk("R11 other active", {31'd0, reg_rdata[11]}, {31'd0, e[11]});
        chk("R7 whole word",    reg_rdata, e);
        @(posedge clk);
        if (!rst_n) begin
            m_nmi = 0; m_svc = 0; m_tick = 0;
        end else begin
            m_nmi  = m_nmi | hw_nmi_req | (reg_wr & reg_wdata[31]);
            if (hw_svc_req || (reg_wr && reg_wdata[28])) m_svc = 1;
            else if (reg_wr && reg_wdata[27]) m_svc = 0;
            if (hw_tick_req || (reg_wr && reg_wdata[26])) m_tick = 1;
            else if (reg_wr && reg_wdata[25]) m_tick = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; reg_wdata = '0;
        hw_nmi_req = 0; hw_svc_req = 0; hw_tick_req = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d; step(); idle();
    endtask

    initial begin
        rst_n = 0; idle();
        act_valid = 0; act_vec = '0; pv_valid = 0; pv_vec = '0;
        ext_act = '0; ext_pend = '0;
        m_nmi = 0; m_svc = 0; m_tick = 0;
        @(negedge clk);
        hw_nmi_req = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
        step(); step(); idle(); step();
        rst_n = 1;
        #2;
        chk("R1 reset flags", {29'd0, nmi_pend, svc_pend, tick_pend}, 32'd0);
        chk("R1 reset word", reg_rdata, 32'd0);
        @(negedge clk);
        // Set each exception in turn.
        wr(32'h1000_0000); step();
        wr(32'h0400_0000); step();
        wr(32'h8000_0000); step();
        // Writes of zero and of read-only bits leave the flags alone.
        wr(32'h0000_0000);
        wr(32'h41FF_FFFF); step();
        #2;
        chk("R6 ignored writes", {29'd0, nmi_pend, svc_pend, tick_pend}, 32'd7);
        @(negedge clk);
        // Clears; set wins when both are written.
        wr(32'h1800_0000); step();
        #2; chk("R3 set wins over clear", {31'd0, svc_pend}, 32'd1); @(negedge clk);
        wr(32'h0800_0000); step();
        #2; chk("R3 clear unpends", {31'd0, svc_pend}, 32'd0); @(negedge clk);
        wr(32'h0600_0000); step();
        #2; chk("R4 set wins over clear", {31'd0, tick_pend}, 32'd1); @(negedge clk);
        wr(32'h0200_0000); step();
        #2; chk("R4 clear unpends", {31'd0, tick_pend}, 32'd0); @(negedge clk);
        // Hardware request against a software clear.
        wr(32'h1400_0000);
        hw_tick_req = 1; hw_svc_req = 1; wr(32'h0A00_0000); step();
        #2; chk("R5 hw wins over clear", {30'd0, svc_pend, tick_pend}, 32'd3); @(negedge clk);
        // Status fields with directed patterns.
        act_valid = 1; act_vec = 9'd20; ext_act = 64'h10; step();
        ext_act = 64'h11; step();
        act_valid = 0; step();
        pv_valid = 1; pv_vec = 9'h1FF; ext_pend = 64'h8000_0000_0000_0000; step();
        pv_valid = 0; ext_pend = '0; act_valid = 1; act_vec = 9'd79;
        ext_act = 64'h8000_0000_0000_0000; step();
        // Random mixed stimulus.
        for (int n = 0; n < 3000; n++) begin
            reg_wr      = ($urandom_range(0, 2) == 0);
            reg_wdata   = $urandom;
            hw_nmi_req  = ($urandom_range(0, 15) == 0);
            hw_svc_req  = ($urandom_range(0, 7) == 0);
            hw_tick_req = ($urandom_range(0, 7) == 0);
            act_valid   = $urandom_range(0, 1);
            pv_valid    = $urandom_range(0, 1);
            pv_vec      = VEC_W'($urandom);
            ext_pend    = ($urandom_range(0, 1) == 0) ? '0 : {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: begin ext_act = '0; act_vec = VEC_W'($urandom); end
                1: begin
                    int ln = $urandom_range(0, NUM_EXT - 1);
                    ext_act = '0; ext_act[ln] = 1'b1; act_vec = VEC_W'(16 + ln);
                end
                2: begin
                    int ln = $urandom_range(0, NUM_EXT - 1);
                    ext_act = '0; ext_act[ln] = 1'b1;
                    act_vec = VEC_W'($urandom_range(0, 15));
                end
                default: begin ext_act = {$urandom, $urandom}; act_vec = VEC_W'($urandom); end
            endcase
            step();
        end
        idle(); step();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule